// File: doc/BRIEF.md
# DMA Copy Address and Word Counters

This block holds the counting state for a memory-to-memory copy. It keeps a source address, a destination address and a count of words still to move. A setup pulse loads both start addresses, the transfer length and a direction bit for each address. After that, the data path raises a strobe once for each word it finishes. Each strobe steps both addresses and lowers the remaining count in the same clock.

A flag goes high once the remaining count is zero. Strobes that arrive after that point do nothing. Each address steps up or down on its own, as its stored direction bit selects. This lets a copy walk upward from a base address or downward from an end address. Addresses roll over at the register width and raise no error. The memory, the bus protocol and the word data path are outside the block.

Top module: `dma_ctr_set`

## Requirements
- R1: While `rst_n` is low, both addresses and the remaining count read zero, both direction bits are cleared (increment), and `xfer_done` reads 1.
- R2: A clock edge with `cfg_load` high copies `cfg_src_addr`, `cfg_dst_addr` and `cfg_len` into `src_addr`, `dst_addr` and `words_left`. The new values are visible after that edge.
- R3: A direction bit of 0 makes its address add one per accepted strobe, and 1 makes it subtract one. The source and destination bits are captured at load, act independently, and hold until the next load.
- R4: An accepted strobe (`word_done` high, `cfg_load` low, `words_left` nonzero) steps both addresses and reduces `words_left` by one on the same edge.
- R5: `xfer_done` is 1 exactly when `words_left` is zero, including right after a load of length zero.
- R6: A strobe while `words_left` is zero moves none of the three counters.
- R7: When `cfg_load` and `word_done` are high on the same edge, the load wins and the strobe is dropped.
- R8: Addresses wrap modulo 2^AW. Stepping up from all ones gives zero, and stepping down from zero gives all ones.
- R9: With both `cfg_load` and `word_done` low, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_load | input | 1 | Setup pulse: load addresses, length and directions |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_len | input | LW | Number of words to transfer |
| cfg_src_dir | input | 1 | Source direction (0 up, 1 down) |
| cfg_dst_dir | input | 1 | Destination direction (0 up, 1 down) |
| word_done | input | 1 | One-cycle strobe per completed word |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| words_left | output | LW | Words still to transfer |
| xfer_done | output | 1 | High when `words_left` is zero |

## Verification
The bench runs four kinds of copy.
- One copy has opposite directions, so a swapped or shared direction bit shows up.
- One copy has same-direction addresses and gaps between strobes, so stepping on idle cycles is caught.
- One copy starts at the all-ones and zero boundaries, to expose any saturation instead of wraparound.
- One copy has length zero, to check that `xfer_done` comes from the count.

Strobes issued after completion, and strobes that coincide with a load, test the gating order between load, step and zero detection.

// File: rtl/dma_ctr_pkg.sv
package dma_ctr_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } step_dir_e;
  localparam int unsigned NUM_ADDR = 2;
  localparam int unsigned IDX_SRC  = 0;
  localparam int unsigned IDX_DST  = 1;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr
  import dma_ctr_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] start_i,
  input  step_dir_e     dir_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] addr_q, addr_d;
  step_dir_e     dir_q, dir_d;
  logic          addr_en;

  always_comb begin
    addr_en = load_i | step_i;
    dir_d   = dir_q;
    addr_d  = addr_q;
    if (load_i) begin
      dir_d  = dir_i;
      addr_d = start_i;
    end else if (step_i) begin
      addr_d = (dir_q == DIR_DOWN) ? (addr_q - ONE) : (addr_q + ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dir_q  <= DIR_UP;
    end else if (addr_en) begin
      addr_q <= addr_d;
      dir_q  <= dir_d;
    end
  end

  assign addr_o = addr_q;

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && dir_q == DIR_UP) |=> addr_o == $past(addr_o) + ONE);

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && dir_q == DIR_DOWN) |=> addr_o == $past(addr_o) - ONE);
endmodule

// File: rtl/dma_word_ctr.sv
module dma_word_ctr #(
  parameter int unsigned LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [LW-1:0] len_i,
  input  logic          step_i,
  output logic [LW-1:0] count_o,
  output logic          zero_o
);
  localparam logic [LW-1:0] ONE = LW'(1);

  logic [LW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i | step_i;
    if (load_i) cnt_d = len_i;
    else        cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
  assign zero_o  = ~|cnt_q;

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> (zero_o && $stable(count_o)));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> count_o == $past(count_o) - ONE);
endmodule

// File: rtl/dma_ctr_set.sv
module dma_ctr_set
  import dma_ctr_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [LW-1:0] cfg_len,
  input  logic          cfg_src_dir,
  input  logic          cfg_dst_dir,
  input  logic          word_done,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [LW-1:0] words_left,
  output logic          xfer_done
);
  logic [NUM_ADDR-1:0][AW-1:0] start_vec, addr_vec;
  step_dir_e [NUM_ADDR-1:0]    dir_vec;
  logic                        cnt_zero;
  logic                        advance;

  assign start_vec[IDX_SRC] = cfg_src_addr;
  assign start_vec[IDX_DST] = cfg_dst_addr;
  assign dir_vec[IDX_SRC]   = step_dir_e'(cfg_src_dir);
  assign dir_vec[IDX_DST]   = step_dir_e'(cfg_dst_dir);

  // strobe is accepted only with work remaining and no load on this edge
  assign advance = word_done & ~cnt_zero & ~cfg_load;

  for (genvar gi = 0; gi < NUM_ADDR; gi++) begin : g_addr
    dma_addr_ctr #(.AW(AW)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (cfg_load),
      .start_i (start_vec[gi]),
      .dir_i   (dir_vec[gi]),
      .step_i  (advance),
      .addr_o  (addr_vec[gi])
    );
  end

  dma_word_ctr #(.LW(LW)) u_words (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (cfg_load),
    .len_i   (cfg_len),
    .step_i  (advance),
    .count_o (words_left),
    .zero_o  (cnt_zero)
  );

  assign src_addr  = addr_vec[IDX_SRC];
  assign dst_addr  = addr_vec[IDX_DST];
  assign xfer_done = cnt_zero;

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (src_addr == $past(cfg_src_addr) && dst_addr == $past(cfg_dst_addr)
                  && words_left == $past(cfg_len)));

  // R9
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && !word_done) |=> ($stable(src_addr) && $stable(dst_addr) && $stable(words_left)));

  // R5
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_done) |-> $past(cfg_load));

  // R6
  after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !cfg_load) |=> ($stable(src_addr) && $stable(dst_addr)));
endmodule

// File: tb/dma_ctr_set_bench.sv
module dma_ctr_set_bench;
  localparam int AW = 16;
  localparam int LW = 16;

  typedef struct {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [LW-1:0] left;
    logic          done;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_load;
  logic [AW-1:0] cfg_src_addr, cfg_dst_addr;
  logic [LW-1:0] cfg_len;
  logic          cfg_src_dir, cfg_dst_dir;
  logic          word_done;
  logic [AW-1:0] src_addr, dst_addr;
  logic [LW-1:0] words_left;
  logic          xfer_done;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  logic [AW-1:0] m_src, m_dst;
  logic [LW-1:0] m_left;
  logic          m_sdir, m_ddir;

  always #10 clk = ~clk;

  dma_ctr_set #(.AW(AW), .LW(LW)) u_dma_ctr_set (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr), .cfg_len(cfg_len),
    .cfg_src_dir(cfg_src_dir), .cfg_dst_dir(cfg_dst_dir), .word_done(word_done),
    .src_addr(src_addr), .dst_addr(dst_addr), .words_left(words_left),
    .xfer_done(xfer_done)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (src_addr !== e.src || dst_addr !== e.dst || words_left !== e.left || xfer_done !== e.done) begin
      errors++;
      $display("FAIL %s: got src=%h dst=%h left=%0d done=%b exp src=%h dst=%h left=%0d done=%b",
               e.tag, src_addr, dst_addr, words_left, xfer_done, e.src, e.dst, e.left, e.done);
    end
  endtask

  // driver: apply one cycle of stimulus and push the model's expectation
  task automatic cyc(input logic ld, input logic [AW-1:0] s, input logic [AW-1:0] d,
                     input logic [LW-1:0] l, input logic sd, input logic dd,
                     input logic st, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_load = ld; cfg_src_addr = s; cfg_dst_addr = d; cfg_len = l;
    cfg_src_dir = sd; cfg_dst_dir = dd; word_done = st;
    if (ld) begin
      m_src = s; m_dst = d; m_left = l; m_sdir = sd; m_ddir = dd;
    end else if (st && m_left != 0) begin
      m_src  = m_sdir ? m_src - 1'b1 : m_src + 1'b1;
      m_dst  = m_ddir ? m_dst - 1'b1 : m_dst + 1'b1;
      m_left = m_left - 1'b1;
    end
    e.src = m_src; e.dst = m_dst; e.left = m_left; e.done = (m_left == 0); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic strobe(input string tag);
    cyc(1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b1, tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // monitor: sample 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_t r;
    rst_n = 1'b0; cfg_load = 0; cfg_src_addr = '0; cfg_dst_addr = '0; cfg_len = '0;
    cfg_src_dir = 0; cfg_dst_dir = 0; word_done = 1'b1;
    m_src = '0; m_dst = '0; m_left = '0; m_sdir = 0; m_ddir = 0;
    repeat (3) @(negedge clk);
    r.src = '0; r.dst = '0; r.left = '0; r.done = 1'b1; r.tag = "R1 reset";
    compare(r);
    word_done = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    // reset-cleared direction bits: strobe at zero does nothing (R6)
    strobe("R6 strobe after reset");
    // opposite directions, length 3
    cyc(1'b1, 16'h1000, 16'h2000, 16'd3, 1'b0, 1'b1, 1'b0, "R2 load opposite dirs");
    strobe("R3 R4 step 1");
    strobe("R3 R4 step 2");
    idle("R9 hold mid copy");
    strobe("R4 R5 final step");
    strobe("R6 strobe after done");
    idle("R9 hold after done");
    // same direction down, gapped strobes
    cyc(1'b1, 16'h0400, 16'h0800, 16'd4, 1'b1, 1'b1, 1'b0, "R2 load both down");
    strobe("R3 down step");
    idle("R9 gap");
    idle("R9 gap 2");
    strobe("R3 down step 2");
    // load with simultaneous strobe
    cyc(1'b1, 16'h0050, 16'h0060, 16'd2, 1'b0, 1'b0, 1'b1, "R7 load beats strobe");
    strobe("R3 up step");
    strobe("R5 reach zero");
    // wraparound
    cyc(1'b1, 16'hFFFF, 16'h0000, 16'd2, 1'b0, 1'b1, 1'b0, "R2 load wrap edges");
    strobe("R8 wrap step");
    strobe("R8 second step after wrap");
    strobe("R6 ignored after wrap copy");
    // zero length
    cyc(1'b1, 16'h1234, 16'h5678, 16'd0, 1'b0, 1'b0, 1'b0, "R5 zero length load");
    strobe("R6 strobe on empty copy");
    idle("R9 final hold");
    @(negedge clk); @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule